// File: doc/BRIEF.md
# Three-State Processor Power Mode Controller

This block steers a processor between three power modes. In RUN the core is fully clocked. In IDLE the core clock is stopped, but interrupt lines are still watched. In SLEEP on-chip activity is shut down. Each change of mode takes a settling time, counted in clock cycles. That time depends on the pair of modes involved. Leaving SLEEP is by far the slowest change, and any change into SLEEP is slower than a change between RUN and IDLE. While a change is settling the block raises a busy flag, and its mode output keeps showing the mode it is leaving.

The block has four sources of requests. Software asks for IDLE. Enabled interrupts ask for RUN. A supply fault forces the processor into SLEEP. An activity input keeps a quiet-period timer from expiring; when the timer does expire, the block puts the processor to SLEEP. Requests that arrive while a change is settling are stored and acted on as soon as it completes, and a stored fault wins over everything else.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After the synchronous active-high reset, `mode_o` is RUN and `busy_o` is low. The mode encoding is RUN=0, IDLE=1, SLEEP=2, and the value 3 never appears.
- R2: When `idle_req` is sampled high while the block is settled in RUN, a RUN-to-IDLE change starts. `busy_o` stays high for LAT_RUN_IDLE cycles, and then `mode_o` becomes IDLE.
- R3: While the block is settled in IDLE, a line that is high in both `irq` and `irq_en` starts an IDLE-to-RUN change lasting LAT_IDLE_RUN cycles. An interrupt whose enable bit is low has no effect.
- R4: While the block is settled in RUN or IDLE, `pwr_fault` high starts a change into SLEEP lasting LAT_TO_SLEEP cycles. A fault takes priority over an idle request, a wake request and the timeout.
- R5: While the block is settled in SLEEP, an enabled interrupt with `pwr_fault` low starts a SLEEP-to-RUN change lasting LAT_SLEEP_RUN cycles. While `pwr_fault` is high the block stays settled in SLEEP.
- R6: While the block is settled in RUN or IDLE, `busy_o` rises, and a change into SLEEP starts, at the (IDLE_TIMEOUT+1)-th consecutive clock edge that samples `activity` low. A single sample of `activity` high restarts the count.
- R7: `mode_o` changes only on the edge where `busy_o` falls. While `busy_o` is high, no new change starts.
- R8: An idle request, an enabled interrupt or a fault sampled while `busy_o` is high is stored. The stored request is acted on in the first settled cycle after the change completes, as if it were present then.
- R9: When a stored fault and a stored idle request are both pending at the end of a change, the block enters SLEEP and does not go to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idle_req | input | 1 | Software request to enter IDLE |
| irq | input | NIRQ | Interrupt lines |
| irq_en | input | NIRQ | Per-line interrupt enable |
| pwr_fault | input | 1 | Supply fault; forces SLEEP |
| activity | input | 1 | Work in progress; restarts the quiet timer |
| mode_o | output | 2 | Current settled mode (0 RUN, 1 IDLE, 2 SLEEP) |
| busy_o | output | 1 | High while a mode change is settling |

## Verification
The delicate cycle is the one where a settling change completes while a stored request is waiting, because the new mode and the next decision meet there. The bench provokes this by pulsing idle requests, faults and interrupts in the middle of slow changes, including an idle request and a fault in the same cycle during a wake from SLEEP. A scoreboard holds the expected sequence of settled modes and settling lengths. Each time busy falls, the monitor compares the new mode with the next item and checks that the measured busy length matches the latency for that mode pair; the fault-priority case passes only if the item after the wake is SLEEP.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_SLEEP = 2'd2
  } pm_mode_e;
endpackage

// File: rtl/pm_settle_counter.sv
module pm_settle_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         active,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (load) begin
      active <= 1'b1;
      cnt_q  <= load_val;
    end else if (active) begin
      if (cnt_q == '0) active <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done = active && (cnt_q == '0);
endmodule

// File: rtl/pm_quiet_timer.sv
module pm_quiet_timer #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic expired
);
  localparam int unsigned TW = (LIMIT > 0) ? $clog2(LIMIT + 1) : 1;
  localparam logic [TW-1:0] LIM = TW'(LIMIT);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear)     cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == LIM);
endmodule

// File: rtl/pm_lat_sel.sv
module pm_lat_sel
  import pwr_mode_pkg::*;
#(
  parameter int unsigned LW            = 4,
  parameter int unsigned LAT_RUN_IDLE  = 3,
  parameter int unsigned LAT_IDLE_RUN  = 3,
  parameter int unsigned LAT_TO_SLEEP  = 6,
  parameter int unsigned LAT_SLEEP_RUN = 10
) (
  input  pm_mode_e      from_mode,
  input  pm_mode_e      to_mode,
  output logic [LW-1:0] cnt_init
);
  always_comb begin
    unique case (to_mode)
      MODE_SLEEP: cnt_init = LW'(LAT_TO_SLEEP - 1);
      MODE_IDLE:  cnt_init = LW'(LAT_RUN_IDLE - 1);
      default:    cnt_init = (from_mode == MODE_SLEEP) ? LW'(LAT_SLEEP_RUN - 1)
                                                       : LW'(LAT_IDLE_RUN - 1);
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned NIRQ          = 4,
  parameter int unsigned LAT_RUN_IDLE  = 1250,
  parameter int unsigned LAT_IDLE_RUN  = 1250,
  parameter int unsigned LAT_TO_SLEEP  = 11250,
  parameter int unsigned LAT_SLEEP_RUN = 20000000,
  parameter int unsigned IDLE_TIMEOUT  = 1000000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            idle_req,
  input  logic [NIRQ-1:0] irq,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            pwr_fault,
  input  logic            activity,
  output logic [1:0]      mode_o,
  output logic            busy_o
);
  localparam int unsigned MAX_A   = (LAT_RUN_IDLE > LAT_IDLE_RUN) ? LAT_RUN_IDLE : LAT_IDLE_RUN;
  localparam int unsigned MAX_B   = (LAT_TO_SLEEP > LAT_SLEEP_RUN) ? LAT_TO_SLEEP : LAT_SLEEP_RUN;
  localparam int unsigned MAX_LAT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned LW      = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1;

  pm_mode_e mode_q, tgt_q, dest;
  logic     start, busy, done, tmo;
  logic     pend_idle, pend_fault, pend_wake;
  logic     wake_hit, eff_idle, eff_fault, eff_wake;
  logic [LW-1:0] cnt_init;

  assign wake_hit  = |(irq & irq_en);
  assign eff_idle  = idle_req  | pend_idle;
  assign eff_fault = pwr_fault | pend_fault;
  assign eff_wake  = wake_hit  | pend_wake;

  // decision in a settled cycle; priority: fault, then explicit request, then timeout
  always_comb begin
    start = 1'b0;
    dest  = mode_q;
    if (!busy) begin
      unique case (mode_q)
        MODE_RUN: begin
          if (eff_fault)     begin start = 1'b1; dest = MODE_SLEEP; end
          else if (eff_idle) begin start = 1'b1; dest = MODE_IDLE;  end
          else if (tmo)      begin start = 1'b1; dest = MODE_SLEEP; end
        end
        MODE_IDLE: begin
          if (eff_fault)     begin start = 1'b1; dest = MODE_SLEEP; end
          else if (eff_wake) begin start = 1'b1; dest = MODE_RUN;   end
          else if (tmo)      begin start = 1'b1; dest = MODE_SLEEP; end
        end
        default: begin
          if (!eff_fault && eff_wake) begin start = 1'b1; dest = MODE_RUN; end
        end
      endcase
    end
  end

  pm_lat_sel #(
    .LW(LW), .LAT_RUN_IDLE(LAT_RUN_IDLE), .LAT_IDLE_RUN(LAT_IDLE_RUN),
    .LAT_TO_SLEEP(LAT_TO_SLEEP), .LAT_SLEEP_RUN(LAT_SLEEP_RUN)
  ) u_lat (
    .from_mode(mode_q), .to_mode(dest), .cnt_init(cnt_init)
  );

  pm_settle_counter #(.W(LW)) u_settle (
    .clk(clk), .rst(rst), .load(start), .load_val(cnt_init),
    .active(busy), .done(done)
  );

  pm_quiet_timer #(.LIMIT(IDLE_TIMEOUT)) u_quiet (
    .clk(clk), .rst(rst),
    .clear(activity | busy | start | (mode_q == MODE_SLEEP)),
    .expired(tmo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_RUN;
      tgt_q      <= MODE_RUN;
      pend_idle  <= 1'b0;
      pend_fault <= 1'b0;
      pend_wake  <= 1'b0;
    end else begin
      if (start) tgt_q  <= dest;
      if (done)  mode_q <= tgt_q;
      if (busy) begin
        pend_idle  <= pend_idle  | idle_req;
        pend_fault <= pend_fault | pwr_fault;
        pend_wake  <= pend_wake  | wake_hit;
      end else begin
        pend_idle  <= 1'b0;
        pend_fault <= 1'b0;
        pend_wake  <= 1'b0;
      end
    end
  end

  assign mode_o = mode_q;
  assign busy_o = busy;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int unsigned NIRQ = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [NIRQ-1:0] irq,
  input logic [NIRQ-1:0] irq_en,
  input logic            pwr_fault,
  input logic [1:0]      mode_o,
  input logic            busy_o
);
  assert_legal_mode_R1: assert property (@(posedge clk) disable iff (rst)
    mode_o != 2'd3);

  assert_mode_at_end_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_o != $past(mode_o)) |-> ($past(busy_o) && !busy_o));

  assert_hold_on_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $stable(mode_o));

  assert_fault_starts_R4: assert property (@(posedge clk) disable iff (rst)
    (pwr_fault && !busy_o && mode_o != 2'd2) |=> busy_o);

  assert_fault_holds_sleep_R5: assert property (@(posedge clk) disable iff (rst)
    (pwr_fault && !busy_o && mode_o == 2'd2) |=> (!busy_o && mode_o == 2'd2));

  assert_idle_wake_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && mode_o == 2'd1 && (|(irq & irq_en))) |=> busy_o);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .irq_en(irq_en), .pwr_fault(pwr_fault),
  .mode_o(mode_o), .busy_o(busy_o)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int NIRQ = 4;
  localparam int RI = 3, IR = 4, TS = 6, SR = 10, TMO = 12;
  localparam logic [1:0] RUN = 2'd0, IDLE = 2'd1, SLEEP = 2'd2;

  typedef struct packed { logic [1:0] m; logic [15:0] lat; } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic idle_req = 1'b0, pwr_fault = 1'b0, activity = 1'b1;
  logic [NIRQ-1:0] irq = '0, irq_en = '0;
  logic [1:0] mode_o;
  logic busy_o;

  int checks = 0, errs = 0, cyc = 0, start_cyc = 0;
  logic prev_busy = 1'b0;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  pwr_mode_ctrl #(
    .NIRQ(NIRQ), .LAT_RUN_IDLE(RI), .LAT_IDLE_RUN(IR), .LAT_TO_SLEEP(TS),
    .LAT_SLEEP_RUN(SR), .IDLE_TIMEOUT(TMO)
  ) u_pwr_mode_ctrl (
    .clk(clk), .rst(rst), .idle_req(idle_req), .irq(irq), .irq_en(irq_en),
    .pwr_fault(pwr_fault), .activity(activity), .mode_o(mode_o), .busy_o(busy_o)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_mode(input logic [1:0] m, input int lat);
    exp_t e;
    e.m = m;
    e.lat = 16'(lat);
    sb_q.push_back(e);
  endtask

  // monitor: on every busy fall, compare new mode and settling length (R2-R5, R7)
  always @(posedge clk) begin
    #2;
    cyc++;
    if (!rst) begin
      if (busy_o && !prev_busy) start_cyc = cyc;
      if (!busy_o && prev_busy) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R7 unexpected mode change", int'(mode_o), -1);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(mode_o == e.m, "R2-R5 settled mode", int'(mode_o), int'(e.m));
          check((cyc - start_cyc) == int'(e.lat), "R2-R5 busy length", cyc - start_cyc, int'(e.lat));
        end
      end
      prev_busy = busy_o;
    end
  end

  task automatic pulse_idle();
    idle_req = 1'b1; @(negedge clk); idle_req = 1'b0;
  endtask
  task automatic pulse_fault();
    pwr_fault = 1'b1; @(negedge clk); pwr_fault = 1'b0;
  endtask
  task automatic pulse_irq();
    irq = 4'b0010; @(negedge clk); irq = '0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    @(negedge clk);
    while ((sb_q.size() != 0 || busy_o) && n < 500) begin
      @(negedge clk);
      n++;
    end
    check(n < 500, req, n, 500);
  endtask

  task automatic count_quiet(input string req);
    int n = 0;
    while (n < 100) begin
      @(posedge clk); #3;
      n++;
      if (busy_o) break;
    end
    check(n == TMO + 1, req, n, TMO + 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(mode_o == RUN, "R1 reset mode", int'(mode_o), int'(RUN));
    check(busy_o == 1'b0, "R1 reset busy", int'(busy_o), 0);

    // R2 idle request, R7 mode held while busy
    expect_mode(IDLE, RI);
    pulse_idle();
    check(busy_o && mode_o == RUN, "R7 mode held during change", int'(mode_o), int'(RUN));
    wait_done("R2 wait");
    check(mode_o == IDLE, "R2 in IDLE", int'(mode_o), int'(IDLE));

    // R3 masked interrupt ignored, then enabled wake
    irq = 4'b0010;
    repeat (5) @(negedge clk);
    check(!busy_o && mode_o == IDLE, "R3 masked irq ignored", int'(mode_o), int'(IDLE));
    expect_mode(RUN, IR);
    irq_en = 4'b0010;
    @(negedge clk); irq = '0;
    wait_done("R3 wait");
    check(mode_o == RUN, "R3 in RUN", int'(mode_o), int'(RUN));

    // R6 timeout with a restart pulse
    expect_mode(SLEEP, TS);
    activity = 1'b0;
    repeat (TMO - 2) @(negedge clk);
    activity = 1'b1;
    @(negedge clk); activity = 1'b0;
    count_quiet("R6 quiet cycles before sleep (RUN)");
    wait_done("R6 wait");
    activity = 1'b1;
    check(mode_o == SLEEP, "R6 in SLEEP", int'(mode_o), int'(SLEEP));

    // R5 fault holds SLEEP despite enabled irq, then wake
    pwr_fault = 1'b1; irq = 4'b0010;
    repeat (6) @(negedge clk);
    check(!busy_o && mode_o == SLEEP, "R5 fault blocks wake", int'(mode_o), int'(SLEEP));
    expect_mode(RUN, SR);
    pwr_fault = 1'b0;
    @(negedge clk); irq = '0;
    wait_done("R5 wait");

    // R8 fault stored during RUN->IDLE
    expect_mode(IDLE, RI); expect_mode(SLEEP, TS);
    pulse_idle();
    pulse_fault();
    wait_done("R8 stored fault wait");
    check(mode_o == SLEEP, "R8 stored fault", int'(mode_o), int'(SLEEP));

    // R8 idle request stored during wake
    expect_mode(RUN, SR); expect_mode(IDLE, RI);
    pulse_irq();
    repeat (2) @(negedge clk);
    pulse_idle();
    wait_done("R8 stored idle wait");
    check(mode_o == IDLE, "R8 stored idle", int'(mode_o), int'(IDLE));

    // R4 fault from IDLE
    expect_mode(SLEEP, TS);
    pulse_fault();
    wait_done("R4 wait");
    check(mode_o == SLEEP, "R4 fault from IDLE", int'(mode_o), int'(SLEEP));

    // R9 stored fault beats stored idle request
    expect_mode(RUN, SR); expect_mode(SLEEP, TS);
    pulse_irq();
    repeat (2) @(negedge clk);
    idle_req = 1'b1; pwr_fault = 1'b1;
    @(negedge clk);
    idle_req = 1'b0; pwr_fault = 1'b0;
    wait_done("R9 wait");
    check(mode_o == SLEEP, "R9 fault wins", int'(mode_o), int'(SLEEP));

    // R6 timeout from IDLE
    expect_mode(RUN, SR);
    pulse_irq();
    wait_done("R6 wake wait");
    expect_mode(IDLE, RI);
    pulse_idle();
    wait_done("R6 idle wait");
    expect_mode(SLEEP, TS);
    activity = 1'b0;
    count_quiet("R6 quiet cycles before sleep (IDLE)");
    wait_done("R6 idle sleep wait");
    check(mode_o == SLEEP && sb_q.size() == 0, "R6 in SLEEP from IDLE", int'(mode_o), int'(SLEEP));

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule